// File: doc/BRIEF.md
# Parallel-Load Shift Register Reader

This block drives an external 8-bit parallel-in, serial-out shift register through four wires: an active-low load strobe, a clock-inhibit line, a serial clock and a serial data return. A one-cycle start request begins one read. The block first holds the load line low so that the external register captures its parallel inputs, such as switch or encoder states. It then drops the inhibit and keeps the serial clock low. It raises the load line, waits a settle time, and gives eight clock pulses. The collected byte comes out with a one-cycle done strobe, and the load line returns low.

The external register shows its most significant bit on the data line as soon as the load line is released, before any clock edge. The block therefore samples that first bit at the end of the settle window, while the clock is still low. It samples each later bit at the end of the low phase that follows a rising edge. The eighth pulse only flushes the external register and yields no sample. When the board wires the inverted serial output to the data input, a parameter turns on a bit-wise inversion so that the byte still reports the true input levels. The clock half-period, the load-low width and the settle time are parameters counted in system clocks.

The controller has six named states. IDLE waits for a start request. The start edge moves it to LOAD. LOAD times out into SETTLE, where the load line is high and the clock low. SETTLE times out into HIGH and takes the first sample. HIGH times out into LOW. LOW times out back into HIGH for pulses one to seven and into DONE after pulse eight. DONE always returns to IDLE one cycle later.

Top module: `shreg_reader`

## Requirements
- R1: After reset, load_n_o is 0, inh_o is 1, sclk_o is 0, done_o is 0 and byte_o is all zeros; the block stays this way until a start request.
- R2: A start_i sampled high in IDLE drops inh_o to 0 at the next edge and keeps load_n_o at 0 for LOAD_W cycles. load_n_o then goes to 1 while sclk_o and inh_o are both 0, and inh_o stays 0 until the block is back in IDLE.
- R3: After load release, sclk_o stays 0 for SETTLE_W cycles. The data input is sampled at the end of that window, before the first rising clock edge, and that sample becomes byte_o bit 7 (the most significant bit).
- R4: After the settle window, sclk_o gives exactly eight pulses, each high for CLK_DIV cycles and then low for CLK_DIV cycles.
- R5: The data input is sampled at the end of the low phase after pulses one to seven. These samples fill byte_o bits 6 down to 0 in that order, so the byte is in most-significant-bit-first order.
- R6: In the cycle after the eighth low phase, done_o is 1 for exactly one cycle. byte_o takes its new value in that same cycle and then holds it until the next done. load_n_o is back at 0 in that cycle, and inh_o returns to 1 in the cycle after.
- R7: With INVERT_DATA = 1, byte_o is the bit-wise inverse of the eight sampled levels, so that a register read through its inverted output reports the true parallel inputs.
- R8: A start_i that arrives while a read is in progress (any state other than IDLE) is ignored: it neither restarts nor lengthens the read, and it leaves no pending request.
- R9: sclk_o is never 1 while load_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request, taken only in IDLE |
| sdata_i | input | 1 | Serial data from the external register (true or inverted output) |
| load_n_o | output | 1 | Active-low parallel-load strobe to the external register |
| inh_o | output | 1 | Clock-inhibit line, low throughout a read |
| sclk_o | output | 1 | Serial shift clock, idles low |
| done_o | output | 1 | One-cycle strobe marking a new byte_o |
| byte_o | output | NBITS | Last byte read, most significant bit first |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is the arrival of a start request and the end of a read. The bench holds start_i high across the DONE cycle and pulses it in the middle of the HIGH and LOW phases. A per-cycle reference model then decides, from its own phase count, whether the block must stay in its current read, start a new one or ignore the request. The second pair is the first-bit sample and load release. An external register model in the bench moves its data only on rising clock edges. Any sample taken one edge late therefore shows up as a wrong bit 7, and a clock pulse that overlaps the release shows up as a wrong byte or a flagged R9 cycle.

// File: rtl/shreg_rd_pkg.sv
package shreg_rd_pkg;

    // Controller states; the encoding carries no meaning outside the block.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_HIGH   = 3'd3,
        ST_LOW    = 3'd4,
        ST_DONE   = 3'd5
    } rd_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/shreg_rd_timer.sv
// Down-counter that times each phase. Loading value V gives V+1 cycles until expiry.
module shreg_rd_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/shreg_rd_shifter.sv
// Gathers serial samples and publishes the finished byte, optionally inverted.
module shreg_rd_shifter #(
    parameter int NBITS       = 8,
    parameter bit INVERT_DATA = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample_en,
    input  logic             sdata,
    input  logic             commit,
    output logic [NBITS-1:0] byte_out
);
    logic [NBITS-1:0] gather;
    logic [NBITS-1:0] fixed;

    // R3 / R5: the first sample ends up in the top bit after NBITS-1 shifts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gather <= '0;
        end else if (clear) begin
            gather <= '0;
        end else if (sample_en) begin
            gather <= {gather[NBITS-2:0], sdata};
        end
    end

    // R7: polarity correction chosen at elaboration.
    generate
        if (INVERT_DATA) begin : g_inv
            assign fixed = ~gather;
        end else begin : g_true
            assign fixed = gather;
        end
    endgenerate

    // R6: the published byte changes only on commit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_out <= '0;
        end else if (commit) begin
            byte_out <= fixed;
        end
    end

endmodule

// File: rtl/shreg_rd_fsm.sv
// Sequencer: state register, next-state/control logic and pin outputs.
module shreg_rd_fsm
    import shreg_rd_pkg::*;
#(
    parameter int NBITS    = 8,
    parameter int CLK_DIV  = 4,
    parameter int LOAD_W   = 2,
    parameter int SETTLE_W = 2,
    parameter int TW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          sample_en,
    output logic          clear,
    output logic          commit,
    output logic          load_n_o,
    output logic          inh_o,
    output logic          sclk_o,
    output logic          done_o,
    output rd_state_t     state_o
);
    localparam int PW = $clog2(NBITS + 1);

    localparam logic [TW-1:0] LOAD_RELOAD   = TW'(LOAD_W - 1);
    localparam logic [TW-1:0] SETTLE_RELOAD = TW'(SETTLE_W - 1);
    localparam logic [TW-1:0] HALF_RELOAD   = TW'(CLK_DIV - 1);
    localparam logic [PW-1:0] LAST_PULSE    = PW'(NBITS - 1);

    rd_state_t       state, state_nx;
    logic [PW-1:0]   pulse, pulse_nx;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pulse <= '0;
        end else begin
            state <= state_nx;
            pulse <= pulse_nx;
        end
    end

    // Transitions and datapath controls.
    always_comb begin
        state_nx  = state;
        pulse_nx  = pulse;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sample_en = 1'b0;
        clear     = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                // R8: requests are looked at here only.
                if (start_i) begin
                    state_nx = ST_LOAD;
                    tmr_load = 1'b1;
                    tmr_val  = LOAD_RELOAD;
                    clear    = 1'b1;
                    pulse_nx = '0;
                end
            end
            ST_LOAD: begin
                if (tmr_expired) begin
                    state_nx = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_RELOAD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    // R3: most significant bit taken while the clock is still low.
                    sample_en = 1'b1;
                    state_nx  = ST_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = HALF_RELOAD;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    state_nx = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_RELOAD;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    if (pulse == LAST_PULSE) begin
                        // R6: eighth pulse is a flush, publish the byte.
                        state_nx = ST_DONE;
                        commit   = 1'b1;
                    end else begin
                        // R5: data moved by the rising edge is now stable.
                        sample_en = 1'b1;
                        state_nx  = ST_HIGH;
                        tmr_load  = 1'b1;
                        tmr_val   = HALF_RELOAD;
                        pulse_nx  = pulse + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Pin outputs decoded from the state register.
    always_comb begin
        load_n_o = 1'b0;
        inh_o    = 1'b0;
        sclk_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                inh_o = 1'b1;
            end
            ST_LOAD: begin
                // R2: inhibit and clock low before the release.
            end
            ST_SETTLE: begin
                load_n_o = 1'b1;
            end
            ST_HIGH: begin
                load_n_o = 1'b1;
                sclk_o   = 1'b1;
            end
            ST_LOW: begin
                load_n_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                inh_o = 1'b1;
            end
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/shreg_reader.sv
// Top level: reads one external parallel-load shift register per start request.
module shreg_reader
    import shreg_rd_pkg::*;
#(
    parameter int NBITS       = 8,
    parameter int CLK_DIV     = 4,
    parameter int LOAD_W      = 2,
    parameter int SETTLE_W    = 2,
    parameter bit INVERT_DATA = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             sdata_i,
    output logic             load_n_o,
    output logic             inh_o,
    output logic             sclk_o,
    output logic             done_o,
    output logic [NBITS-1:0] byte_o
);
    localparam int MAXCNT = max3(CLK_DIV, LOAD_W, SETTLE_W);
    localparam int TW     = (MAXCNT < 2) ? 1 : $clog2(MAXCNT);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          sample_en;
    logic          clear;
    logic          commit;
    rd_state_t     state;

    shreg_rd_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    shreg_rd_fsm #(
        .NBITS    (NBITS),
        .CLK_DIV  (CLK_DIV),
        .LOAD_W   (LOAD_W),
        .SETTLE_W (SETTLE_W),
        .TW       (TW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .sample_en   (sample_en),
        .clear       (clear),
        .commit      (commit),
        .load_n_o    (load_n_o),
        .inh_o       (inh_o),
        .sclk_o      (sclk_o),
        .done_o      (done_o),
        .state_o     (state)
    );

    shreg_rd_shifter #(
        .NBITS       (NBITS),
        .INVERT_DATA (INVERT_DATA)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .sample_en (sample_en),
        .sdata     (sdata_i),
        .commit    (commit),
        .byte_out  (byte_o)
    );

endmodule

// File: rtl/shreg_reader_chk.sv
// Protocol checker attached to every shreg_reader instance.
module shreg_reader_chk
    import shreg_rd_pkg::*;
#(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             load_n_o,
    input logic             inh_o,
    input logic             sclk_o,
    input logic             done_o,
    input logic [NBITS-1:0] byte_o,
    input rd_state_t        state
);
    // R2: clock and inhibit low at the moment the load line rises.
    p_safe_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_n_o) |-> (!sclk_o && !inh_o));

    // R2: inhibit stays low while the load line is released.
    p_inh_low_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_n_o |-> !inh_o);

    // R9: no clock activity while the parallel load is active.
    p_no_clk_in_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_o |-> !sclk_o);

    // R6: done is a single-cycle strobe.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: published byte changes only together with done.
    p_byte_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(byte_o) |-> done_o);

    // R8: a request during the clocking phases never re-enters the load phase.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HIGH || state == ST_LOW) && start_i) |=> (state != ST_LOAD));

endmodule

bind shreg_reader shreg_reader_chk #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .load_n_o (load_n_o),
    .inh_o    (inh_o),
    .sclk_o   (sclk_o),
    .done_o   (done_o),
    .byte_o   (byte_o),
    .state    (state)
);

// File: tb/shreg_reader_bench.sv
// Behavioural model of the external parallel-in/serial-out register.
module shreg_dev_model (
    input  logic       clk,
    input  logic [7:0] pins,
    input  logic       load_n,
    input  logic       inh,
    input  logic       sclk,
    output logic       q,
    output logic       qn
);
    logic [7:0] r = 8'h00;
    logic       sclk_prev = 1'b0;

    // Updated mid-cycle, away from the controller's sampling edge.
    always @(negedge clk) begin
        if (!load_n) begin
            r = pins;
        end else if (sclk && !sclk_prev && !inh) begin
            r = {r[6:0], 1'b0};
        end
        sclk_prev = sclk;
    end

    assign q  = r[7];
    assign qn = ~r[7];
endmodule

module shreg_reader_bench;
    localparam int NB  = 8;
    localparam int DIV = 2;
    localparam int LW  = 3;
    localparam int SW  = 2;
    localparam int TOTAL = LW + SW + 2 * NB * DIV + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] pins = 8'h00;

    logic a_load_n, a_inh, a_sclk, a_done;
    logic b_load_n, b_inh, b_sclk, b_done;
    logic [NB-1:0] a_byte, b_byte;
    logic a_q, a_qn, b_q, b_qn;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m_t = -1;
    int m_done_cnt = 0;
    int a_done_cnt = 0;
    logic [7:0] m_latch = 8'h00;
    logic [7:0] m_byte  = 8'h00;

    always #10 clk = ~clk;

    shreg_reader #(.NBITS(NB), .CLK_DIV(DIV), .LOAD_W(LW), .SETTLE_W(SW),
                   .INVERT_DATA(1'b0)) u_shreg_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sdata_i(a_q),
        .load_n_o(a_load_n), .inh_o(a_inh), .sclk_o(a_sclk),
        .done_o(a_done), .byte_o(a_byte));

    shreg_reader #(.NBITS(NB), .CLK_DIV(DIV), .LOAD_W(LW), .SETTLE_W(SW),
                   .INVERT_DATA(1'b1)) u_shreg_reader_inv (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sdata_i(b_qn),
        .load_n_o(b_load_n), .inh_o(b_inh), .sclk_o(b_sclk),
        .done_o(b_done), .byte_o(b_byte));

    shreg_dev_model u_dev_a (.clk(clk), .pins(pins), .load_n(a_load_n), .inh(a_inh),
                             .sclk(a_sclk), .q(a_q), .qn(a_qn));
    shreg_dev_model u_dev_b (.clk(clk), .pins(pins), .load_n(b_load_n), .inh(b_inh),
                             .sclk(b_sclk), .q(b_q), .qn(b_qn));

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    // Reference phase counter: advances on each edge, starts only from idle.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_t = -1;
        end else if (m_t < 0) begin
            if (start) m_t = 0;
        end else begin
            m_t++;
            if (m_t == TOTAL) m_t = -1;
        end
        if (m_t == TOTAL - 1) begin
            m_byte = m_latch;
            m_done_cnt++;
        end
    end

    // Per-cycle comparison of both instances against the reference.
    always @(negedge clk) begin
        logic e_load_n, e_inh, e_sclk, e_done;
        string ph_tag;
        int k;
        if (rst_n) begin
            e_load_n = 1'b0; e_inh = 1'b0; e_sclk = 1'b0; e_done = 1'b0;
            ph_tag = "R2";
            if (m_t < 0) begin
                e_inh = 1'b1; ph_tag = "R1";
            end else if (m_t < LW) begin
                m_latch = pins;
            end else if (m_t < LW + SW) begin
                e_load_n = 1'b1; ph_tag = "R3";
            end else if (m_t < TOTAL - 1) begin
                k = m_t - LW - SW;
                e_load_n = 1'b1;
                e_sclk = ((k / DIV) % 2) == 0;
                ph_tag = "R4";
            end else begin
                e_done = 1'b1; ph_tag = "R6";
            end
            check(ph_tag, "load_n", int'(a_load_n), int'(e_load_n));
            check(ph_tag, "inh", int'(a_inh), int'(e_inh));
            check(ph_tag, "sclk", int'(a_sclk), int'(e_sclk));
            check("R6", "done", int'(a_done), int'(e_done));
            check((a_byte[7] != m_byte[7]) ? "R3" : "R5", "byte", int'(a_byte), int'(m_byte));
            check(ph_tag, "inv load_n", int'(b_load_n), int'(e_load_n));
            check(ph_tag, "inv sclk", int'(b_sclk), int'(e_sclk));
            check("R6", "inv done", int'(b_done), int'(e_done));
            check("R7", "inv byte", int'(b_byte), int'(m_byte));
            check("R9", "clock during load", int'(a_sclk && !a_load_n), 0);
            if (a_done) a_done_cnt++;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_one(input logic [7:0] val);
        @(negedge clk);
        pins  = val;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cycles(TOTAL + 2);
    endtask

    initial begin : watchdog
        wait_cycles(20000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        wait_cycles(3);
        // R1: reset state seen at the pins.
        check("R1", "reset load_n", int'(a_load_n), 0);
        check("R1", "reset inh", int'(a_inh), 1);
        check("R1", "reset sclk", int'(a_sclk), 0);
        check("R1", "reset done", int'(a_done), 0);
        check("R1", "reset byte", int'(a_byte), 0);
        rst_n = 1'b1;
        wait_cycles(4);

        read_one(8'hA5);
        read_one(8'h80);   // R3: only the first-sampled bit set
        read_one(8'h01);   // R5: only the last-sampled bit set
        read_one(8'hFF);
        read_one(8'h00);

        // R8: extra requests in the middle of a read are ignored.
        @(negedge clk);
        pins = 8'h3C; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cycles(8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cycles(12);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cycles(TOTAL);

        // Pins change after release: the byte keeps the loaded value (R2, R5).
        @(negedge clk);
        pins = 8'h5A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cycles(LW + SW + 1);
        pins = 8'hC3;
        wait_cycles(TOTAL);

        // Request held high across DONE: reads run back to back (R6, R8).
        @(negedge clk);
        pins = 8'h69; start = 1'b1;
        wait_cycles(2 * TOTAL + 2);
        start = 1'b0;
        wait_cycles(TOTAL + 4);

        check("R8", "done pulse count", a_done_cnt, m_done_cnt);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule